// File: doc/BRIEF.md
# Four-Channel Transfer Register File and Scheduler

This block is the programming front end of a four-channel memory-to-memory transfer unit. Software reaches it through a 32-bit word access port. Each channel has four registers: a source address, a destination address, a transfer count and a command word. One more address returns a fixed revision code. Writing a command word with its start bit set makes that channel eligible for the shared data path.

The scheduler grants the data path to one started channel at a time. It shows the owner's registers to the external transfer engine. The engine reports back with done, stall and error pulses. On a done or error pulse, the block clears the owner's start bit and, if enabled, sets a status bit. The grant then moves on to the next started channel, in rising index order with wrap-around. A single interrupt line is high while any channel holds a status bit. Software clears status bits by rewriting the command word.

Top module: `dma_regfile_arb`

## Requirements
- R1: Reset clears every channel's source, destination, count and command register to zero. It also drops the grant and the interrupt, and drives read data to zero.
- R2: Channel n (0..3) decodes at byte address 0x80 + 16·n. The source register is at +0x0, the destination at +0x4, the count at +0x8 and the command at +0xC. A read returns the register value on `acc_rdata` in the cycle after the access. `acc_rdata` is zero in cycles that follow no read.
- R3: Address 0xC8 reads as 0x00010800, and writes to it change nothing.
- R4: A read of any other address returns 0, and a write to it changes no register. This includes addresses with bits [1:0] not zero.
- R5: An access with `acc_word` low is not a 32-bit access. It writes nothing, and its read returns 0.
- R6: A count write stores only bits [23:0] of the write data. A count read returns those bits with bits [31:24] at zero.
- R7: Command bit 0 is the start bit. A write that sets it while no channel holds the grant grants that channel in the next cycle. A channel started while another holds the grant waits, and the current grant is kept.
- R8: At most one channel is granted at any time, and `gnt_valid` is high exactly when one is.
- R9: A `eng_done` pulse clears the owner's start bit. If command bit 2 is set, it also sets command bit 1 (finish). In the next cycle the grant goes to the first started channel after the owner, searching upward in index order with wrap-around. If no channel is started, the grant drops.
- R10: A `eng_err` pulse clears the owner's start bit and sets command bit 4 (error) if command bit 5 is set. The grant then moves as in R9.
- R11: A `eng_stall` pulse keeps the owner's start bit and passes the grant to the next started channel in wrap-around order. If the owner is the only started channel, it is granted again.
- R12: `irq` is high exactly while some channel's command register has bit 1 or bit 4 set. Writing the command word with those bits at 0 clears them.
- R13: `xfer_src`, `xfer_dst`, `xfer_cnt` and `xfer_cmd` show the granted channel's registers. They are all zero while no channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | Access is a full 32-bit word |
| acc_addr | input | 12 | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| eng_done | input | 1 | Engine finished the granted channel |
| eng_stall | input | 1 | Engine stalled on the granted channel's handshake |
| eng_err | input | 1 | Engine hit an error on the granted channel |
| gnt | output | 4 | One-hot channel grant |
| gnt_valid | output | 1 | A channel holds the grant |
| xfer_src | output | 32 | Granted channel's source address |
| xfer_dst | output | 32 | Granted channel's destination address |
| xfer_cnt | output | 24 | Granted channel's transfer count |
| xfer_cmd | output | 32 | Granted channel's command word |
| irq | output | 1 | Any channel has finish or error status |

## Verification
The assertions check the following on every cycle:
- The grant stays one-hot or empty.
- Without a bus access, a grant never appears from nothing, and a done pulse always moves it off the owner.
- A stall never leaves the path idle.
- An enabled done or error raises the interrupt.
- The revision code and non-word reads always return their fixed values.

Only the bench's scenarios can show the register map and the 24-bit count truncation. The same holds for the wrap-around order of grant hand-over and for the exact command-word values after done, error and stall. The bench also shows interrupt clearing by software rewrite and the effect of reset in the middle of a transfer.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CNT_W     = 24;
    localparam logic [11:0] CH_BASE   = 12'h080;
    localparam logic [11:0] REV_ADDR  = 12'h0C8;
    localparam logic [31:0] REV_VALUE = 32'h0001_0800;

    // command word bit positions
    localparam int unsigned CMD_GO     = 0;
    localparam int unsigned CMD_FIN    = 1;
    localparam int unsigned CMD_FIN_EN = 2;
    localparam int unsigned CMD_ERR    = 4;
    localparam int unsigned CMD_ERR_EN = 5;

    // register select follows address bits [3:2]
    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CMD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] cmd;
    } chan_regs_t;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
    import dma_rf_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              acc_en,
    input  logic              acc_word,
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    ch_hit,
    output reg_sel_e          sel,
    output logic              rev_hit
);
    localparam int unsigned SLOT_W = ADDR_W - 4;

    logic              legal;
    logic              in_win;
    logic [SLOT_W-1:0] slot;

    assign legal  = acc_en && acc_word && (addr[1:0] == 2'b00);
    assign in_win = addr >= ADDR_W'(CH_BASE);
    assign slot   = addr[ADDR_W-1:4] - SLOT_W'(CH_BASE >> 4);

    always_comb begin
        rev_hit = legal && (addr == ADDR_W'(REV_ADDR));
        sel     = reg_sel_e'(addr[3:2]);
        ch_hit  = '0;
        for (int n = 0; n < NCH; n++) begin
            if (legal && in_win && !rev_hit && (slot == SLOT_W'(n))) begin
                ch_hit[n] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
    import dma_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              granted,
    input  logic              eng_done,
    input  logic              eng_err,
    output chan_regs_t        regs,
    output logic              start_nxt
);
    chan_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // engine events touch only the owner
        if (granted && eng_done) begin
            r_d.cmd[CMD_GO] = 1'b0;
            if (r_q.cmd[CMD_FIN_EN]) r_d.cmd[CMD_FIN] = 1'b1;
        end
        if (granted && eng_err) begin
            r_d.cmd[CMD_GO] = 1'b0;
            if (r_q.cmd[CMD_ERR_EN]) r_d.cmd[CMD_ERR] = 1'b1;
        end
        // a software write in the same cycle takes precedence
        if (wr_en) begin
            unique case (sel)
                SEL_SRC: r_d.src = wdata;
                SEL_DST: r_d.dst = wdata;
                SEL_CNT: r_d.cnt = wdata[CNT_W-1:0];
                SEL_CMD: r_d.cmd = wdata;
                default: r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs      = r_q;
    assign start_nxt = r_d.cmd[CMD_GO];
endmodule

// File: rtl/dma_rf_arbiter.sv
module dma_rf_arbiter #(
    parameter int unsigned NCH  = 4,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  start_nxt,
    input  logic            eng_done,
    input  logic            eng_stall,
    input  logic            eng_err,
    output logic [NCH-1:0]  gnt,
    output logic            gnt_valid,
    output logic [CH_W-1:0] gnt_idx
);
    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] idx;
    } arb_st_t;

    arb_st_t s_d, s_q;
    logic    move;
    int      base;

    assign move = !s_q.valid || eng_done || eng_stall || eng_err || !start_nxt[s_q.idx];
    assign base = s_q.valid ? int'(s_q.idx) + 1 : 0;

    always_comb begin
        s_d = s_q;
        if (move) begin
            s_d.valid = 1'b0;
            for (int k = 0; k < NCH; k++) begin
                if (!s_d.valid && start_nxt[(base + k) % NCH]) begin
                    s_d.valid = 1'b1;
                    s_d.idx   = CH_W'((base + k) % NCH);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_gnt
        assign gnt[n] = s_q.valid && (s_q.idx == CH_W'(n));
    end
    assign gnt_valid = s_q.valid;
    assign gnt_idx   = s_q.idx;
endmodule

// File: rtl/dma_regfile_arb.sv
module dma_regfile_arb
    import dma_rf_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_word,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              eng_done,
    input  logic              eng_stall,
    input  logic              eng_err,
    output logic [NCH-1:0]    gnt,
    output logic              gnt_valid,
    output logic [31:0]       xfer_src,
    output logic [31:0]       xfer_dst,
    output logic [23:0]       xfer_cnt,
    output logic [31:0]       xfer_cmd,
    output logic              irq
);
    localparam int unsigned CH_W = $clog2(NCH);

    logic [NCH-1:0]    ch_hit;
    reg_sel_e          sel;
    logic              rev_hit;
    logic [NCH-1:0]    start_nxt;
    logic [CH_W-1:0]   gnt_idx;
    chan_regs_t        ch_regs [NCH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    dma_rf_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) i_decode (
        .acc_en  (acc_en),
        .acc_word(acc_word),
        .addr    (acc_addr),
        .ch_hit  (ch_hit),
        .sel     (sel),
        .rev_hit (rev_hit)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        dma_rf_chan i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_hit[n] && acc_wr),
            .sel      (sel),
            .wdata    (acc_wdata),
            .granted  (gnt[n]),
            .eng_done (eng_done),
            .eng_err  (eng_err),
            .regs     (ch_regs[n]),
            .start_nxt(start_nxt[n])
        );
    end

    dma_rf_arbiter #(.NCH(NCH)) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_nxt(start_nxt),
        .eng_done (eng_done),
        .eng_stall(eng_stall),
        .eng_err  (eng_err),
        .gnt      (gnt),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    // read path: registered, zero when no read is decoded
    always_comb begin
        rdata_d = '0;
        if (acc_en && !acc_wr) begin
            if (rev_hit) rdata_d = REV_VALUE;
            for (int n = 0; n < NCH; n++) begin
                if (ch_hit[n]) begin
                    unique case (sel)
                        SEL_SRC: rdata_d = ch_regs[n].src;
                        SEL_DST: rdata_d = ch_regs[n].dst;
                        SEL_CNT: rdata_d = DATA_W'(ch_regs[n].cnt);
                        SEL_CMD: rdata_d = ch_regs[n].cmd;
                        default: rdata_d = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end
    assign acc_rdata = rdata_q;

    always_comb begin
        irq = 1'b0;
        for (int n = 0; n < NCH; n++) begin
            irq = irq | ch_regs[n].cmd[CMD_FIN] | ch_regs[n].cmd[CMD_ERR];
        end
    end

    always_comb begin
        xfer_src = '0;
        xfer_dst = '0;
        xfer_cnt = '0;
        xfer_cmd = '0;
        if (gnt_valid) begin
            xfer_src = ch_regs[gnt_idx].src;
            xfer_dst = ch_regs[gnt_idx].dst;
            xfer_cnt = ch_regs[gnt_idx].cnt;
            xfer_cmd = ch_regs[gnt_idx].cmd;
        end
    end
endmodule

// File: rtl/dma_rf_checker.sv
module dma_rf_checker
    import dma_rf_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic              acc_word,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_rdata,
    input logic              eng_done,
    input logic              eng_stall,
    input logic              eng_err,
    input logic [NCH-1:0]    gnt,
    input logic              gnt_valid,
    input logic [31:0]       xfer_cmd,
    input logic              irq
);
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_valid == (gnt != '0)));

    assert_no_spurious_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && !acc_en) |=> !gnt_valid);

    assert_done_moves_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && eng_done && !acc_en) |=> ((gnt & $past(gnt)) == '0));

    assert_done_raises_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && eng_done && xfer_cmd[CMD_FIN_EN] && !acc_en) |=> irq);

    assert_err_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && eng_err && xfer_cmd[CMD_ERR_EN] && !acc_en) |=> irq);

    assert_stall_keeps_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && eng_stall && !eng_done && !eng_err && !acc_en) |=> gnt_valid);

    assert_revision_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_word && acc_addr == ADDR_W'(REV_ADDR)) |=> (acc_rdata == REV_VALUE));

    assert_narrow_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !acc_word) |=> (acc_rdata == '0));

    assert_idle_view_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (xfer_cmd == '0));
endmodule

bind dma_regfile_arb dma_rf_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_word (acc_word),
    .acc_addr (acc_addr),
    .acc_rdata(acc_rdata),
    .eng_done (eng_done),
    .eng_stall(eng_stall),
    .eng_err  (eng_err),
    .gnt      (gnt),
    .gnt_valid(gnt_valid),
    .xfer_cmd (xfer_cmd),
    .irq      (irq)
);

// File: tb/test_dma_regfile_arb.sv
`timescale 1ns/1ps
module test_dma_regfile_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_word = 1'b1;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        eng_done = 1'b0, eng_stall = 1'b0, eng_err = 1'b0;
    logic [3:0]  gnt;
    logic        gnt_valid;
    logic [31:0] xfer_src, xfer_dst, xfer_cmd;
    logic [23:0] xfer_cnt;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_regfile_arb i_dma_regfile_arb (
        .clk(clk), .rst_n(rst_n),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_word(acc_word),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .eng_done(eng_done), .eng_stall(eng_stall), .eng_err(eng_err),
        .gnt(gnt), .gnt_valid(gnt_valid),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_cnt(xfer_cnt),
        .xfer_cmd(xfer_cmd), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] expv;
    } vec_t;

    // write then read back; expected value from R2, R3, R4, R6
    localparam vec_t VECS [12] = '{
        '{12'h080, 32'h1000_0000, 32'h1000_0000},
        '{12'h084, 32'h2000_0040, 32'h2000_0040},
        '{12'h088, 32'hAB12_3456, 32'h0012_3456},
        '{12'h090, 32'h3333_0004, 32'h3333_0004},
        '{12'h09C, 32'h0000_0024, 32'h0000_0024},
        '{12'h0A4, 32'hDEAD_BEEC, 32'hDEAD_BEEC},
        '{12'h0B8, 32'h00FF_FFFF, 32'h00FF_FFFF},
        '{12'h0B0, 32'h4444_0000, 32'h4444_0000},
        '{12'h0C8, 32'h0000_1234, 32'h0001_0800},
        '{12'h0C0, 32'h0000_FFFF, 32'h0000_0000},
        '{12'h000, 32'h5A5A_5A5A, 32'h0000_0000},
        '{12'h0FC, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic word);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; acc_word = word;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_word = 1'b1;
    endtask

    task automatic pulse(input logic dn, input logic st, input logic er);
        @(negedge clk);
        eng_done = dn; eng_stall = st; eng_err = er;
        @(negedge clk);
        eng_done = 1'b0; eng_stall = 1'b0; eng_err = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] expv);
        bus(1'b0, a, 32'h0, 1'b1);
        check(req, acc_rdata, expv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 gnt", {28'h0, gnt}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rdata", acc_rdata, 32'h0);
        rst_n = 1'b1;
        rd_check("R1 ch0 src", 12'h080, 32'h0);
        rd_check("R1 ch3 cmd", 12'h0BC, 32'h0);

        // R2 R3 R4 R6: table walk
        for (int i = 0; i < 12; i++) begin
            bus(1'b1, VECS[i].addr, VECS[i].wdata, 1'b1);
            rd_check("R2/R3/R4/R6 table", VECS[i].addr, VECS[i].expv);
        end
        check("R2 idle rdata", acc_rdata, 32'h0);
        @(negedge clk);
        check("R2 rdata zero after read", acc_rdata, 32'h0);

        // R7 R13: start ch2 from idle
        bus(1'b1, 12'h0AC, 32'h25, 1'b1);
        check("R7 grant ch2", {28'h0, gnt}, 32'h4);
        check("R13 xfer_dst", xfer_dst, 32'hDEAD_BEEC);
        check("R12 irq low", {31'h0, irq}, 32'h0);
        bus(1'b1, 12'h08C, 32'h05, 1'b1);
        check("R7 waits", {28'h0, gnt}, 32'h4);

        // R9: done on ch2, wraps to ch0
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 grant wraps to ch0", {28'h0, gnt}, 32'h1);
        check("R12 irq on finish", {31'h0, irq}, 32'h1);
        check("R13 xfer_src", xfer_src, 32'h1000_0000);
        check("R13 xfer_cnt", {8'h0, xfer_cnt}, 32'h0012_3456);
        rd_check("R9 ch2 cmd", 12'h0AC, 32'h26);

        // R11: stall hands over and back
        bus(1'b1, 12'h09C, 32'h25, 1'b1);
        check("R7 ch1 waits", {28'h0, gnt}, 32'h1);
        pulse(1'b0, 1'b1, 1'b0);
        check("R11 grant ch1", {28'h0, gnt}, 32'h2);
        rd_check("R11 ch0 keeps start", 12'h08C, 32'h05);
        pulse(1'b0, 1'b1, 1'b0);
        check("R11 grant back ch0", {28'h0, gnt}, 32'h1);

        // R10: error without and with enable
        pulse(1'b0, 1'b0, 1'b1);
        rd_check("R10 ch0 no err bit", 12'h08C, 32'h04);
        check("R10 grant ch1", {28'h0, gnt}, 32'h2);
        pulse(1'b0, 1'b0, 1'b1);
        rd_check("R10 ch1 err bit", 12'h09C, 32'h34);
        check("R9 grant drops", {31'h0, gnt_valid}, 32'h0);
        check("R13 idle xfer_cmd", xfer_cmd, 32'h0);

        // R12: clear by rewrite
        bus(1'b1, 12'h0AC, 32'h0, 1'b1);
        check("R12 irq held by err", {31'h0, irq}, 32'h1);
        bus(1'b1, 12'h09C, 32'h0, 1'b1);
        check("R12 irq cleared", {31'h0, irq}, 32'h0);

        // R9: order 3 -> 1 -> 2 with wrap, no finish enable
        bus(1'b1, 12'h0BC, 32'h01, 1'b1);
        bus(1'b1, 12'h09C, 32'h01, 1'b1);
        bus(1'b1, 12'h0AC, 32'h01, 1'b1);
        check("R9 grant ch3", {28'h0, gnt}, 32'h8);
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 wrap to ch1", {28'h0, gnt}, 32'h2);
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 then ch2", {28'h0, gnt}, 32'h4);
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 all done", {31'h0, gnt_valid}, 32'h0);
        check("R12 no enable no irq", {31'h0, irq}, 32'h0);
        rd_check("R9 ch3 cmd cleared", 12'h0BC, 32'h0);

        // R5: narrow accesses
        bus(1'b1, 12'h080, 32'h5555_5555, 1'b0);
        rd_check("R5 narrow write ignored", 12'h080, 32'h1000_0000);
        bus(1'b0, 12'h080, 32'h0, 1'b0);
        check("R5 narrow read zero", acc_rdata, 32'h0);

        // R4: misaligned write ignored
        bus(1'b1, 12'h082, 32'h7777_7777, 1'b1);
        rd_check("R4 misaligned ignored", 12'h080, 32'h1000_0000);

        // R1: reset in the middle of a grant
        bus(1'b1, 12'h08C, 32'h05, 1'b1);
        check("R7 grant ch0", {28'h0, gnt}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 gnt after reset", {28'h0, gnt}, 32'h0);
        rst_n = 1'b1;
        rd_check("R1 src cleared", 12'h080, 32'h0);
        rd_check("R1 cmd cleared", 12'h08C, 32'h0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule